// File: doc/BRIEF.md
# Program/Erase Suspend Status Tracker

This block holds the volatile suspend status byte of a serial flash controller. It follows the embedded algorithm controller through a small state machine: idle, running, suspending, suspended and resuming. From that it records whether a suspended operation was an erase or a program. It keeps a sticky failure flag and reflects the live write-enable latch. It also drives the write-in-progress indication that the main status register shares.

The command decoder presents an opcode with a valid strobe. When the opcode is the read-suspend-status instruction, the block takes a snapshot of the byte and shifts it out one bit per clock, most significant bit first. The embedded program and erase algorithms are outside this block. They only deliver start, done, fail, suspend and resume strobes.

Top module: `suspstat_top`

## Requirements
- R1: After the asynchronous reset `rstN`, every bit of `suspStatus` is 0 apart from bit 1, which follows `welIn`; `wip`, `sdo` and `sdoValid` are 0.
- R2: A suspend request accepted while an erase (`opKind` = 1) runs sets bit 2 (erase suspended) exactly `SUSP_CYCLES` clocks after the request edge; bit 2 and bit 3 are never both 1.
- R3: A suspend request accepted while a program (`opKind` = 0) runs sets bit 3 (program suspended) exactly `SUSP_CYCLES` clocks after the request edge.
- R4: A resume request accepted in the suspended state clears the set suspended bit `RES_CYCLES` clocks after the request edge, and the operation runs again.
- R5: Bit 1 mirrors `welIn`; a suspend or resume request sampled while `welIn` is 0 is rejected and changes nothing.
- R6: A suspend request with no suspendable operation running (idle, or a status write, `opKind` = 2) has no effect, and a resume request with neither suspended bit set is ignored.
- R7: Bit 5 (fail) goes to 1 on `opFail` during a running operation and stays 1 until a new operation starts from idle or `swReset` is pulsed.
- R8: Bits 6, 4 and 0 of `suspStatus` always read 0.
- R9: `cmdValid` with `cmdOpcode` = 09h, while no read is shifting, snapshots the byte; from the next clock `sdoValid` is 1 for 8 clocks and `sdo` carries bits 7 down to 0. Any other opcode produces no output.
- R10: `wip` is 1 while an operation runs and for the whole suspend and resume transitions, 0 while suspended or idle, and bit 7 always equals `wip`.
- R11: `swReset` returns state, suspended bits and the fail flag to their power-up values from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| swReset | input | 1 | Synchronous software reset strobe |
| opStart | input | 1 | Embedded operation start strobe |
| opKind | input | 2 | Kind of operation on start: 0 program, 1 erase, 2 status write |
| opDone | input | 1 | Embedded operation finished strobe |
| opFail | input | 1 | Embedded operation failed strobe |
| suspendReq | input | 1 | Suspend instruction strobe |
| resumeReq | input | 1 | Resume instruction strobe |
| welIn | input | 1 | Live write-enable latch |
| cmdValid | input | 1 | Decoded opcode valid |
| cmdOpcode | input | 8 | Decoded opcode |
| wip | output | 1 | Write in progress |
| suspStatus | output | 8 | Live suspend status byte |
| sdo | output | 1 | Serial status bit |
| sdoValid | output | 1 | Serial bit valid |

## Verification
The suspend and resume cycle is run once for an erase and once for a program. This separates the two suspended bits and shows that the operation kind is captured at start. The same requests are then repeated with the write-enable latch low, while idle, during a status write and with nothing suspended. These runs separate the gating rules from the plain transition path. Failure is raised and then cleared once by a new start and once by software reset, so the two clear paths are seen apart. The transition length is checked one clock before and at the expected edge, and a serial read of a suspended state is compared bit by bit against a non-matching opcode.

// File: rtl/suspstat_pkg.sv
package suspstat_pkg;

  typedef enum logic [1:0] {
    KIND_PROG  = 2'd0,
    KIND_ERASE = 2'd1,
    KIND_WRSR  = 2'd2,
    KIND_RSVD  = 2'd3
  } opKind_e;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_RUN        = 3'd1,
    ST_SUSPENDING = 3'd2,
    ST_SUSPENDED  = 3'd3,
    ST_RESUMING   = 3'd4
  } ctrlState_e;

  typedef struct packed {
    logic setEraseSusp;
    logic setProgSusp;
    logic clrSusp;
    logic setFail;
    logic clrFail;
    logic clrAll;
  } ctrlStrobes_t;

  localparam int STATUS_W = 8;
  localparam int BIT_WIP  = 7;
  localparam int BIT_FAIL = 5;
  localparam int BIT_PSUS = 3;
  localparam int BIT_ESUS = 2;
  localparam int BIT_WEL  = 1;

endpackage

// File: rtl/suspstat_ctrl.sv
module suspstat_ctrl
  import suspstat_pkg::*;
#(
  parameter int SUSP_CYCLES = 4,
  parameter int RES_CYCLES  = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         swReset,
  input  logic         opStart,
  input  logic [1:0]   opKind,
  input  logic         opDone,
  input  logic         opFail,
  input  logic         suspendReq,
  input  logic         resumeReq,
  input  logic         welIn,
  output ctrlStrobes_t stb,
  output logic         wip
);

  localparam int MAX_CYC = (SUSP_CYCLES > RES_CYCLES) ? SUSP_CYCLES : RES_CYCLES;
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC + 1) : 1;
  localparam logic [CNT_W-1:0] SUSP_LOAD = CNT_W'(SUSP_CYCLES - 1);
  localparam logic [CNT_W-1:0] RES_LOAD  = CNT_W'(RES_CYCLES - 1);

  ctrlState_e       state, nextState;
  opKind_e          kind, nextKind;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic             suspendable;

  assign suspendable = (kind == KIND_PROG) || (kind == KIND_ERASE);

  always_comb begin
    nextState = state;
    nextKind  = kind;
    nextCnt   = cnt;
    stb       = '0;
    if (swReset) begin
      nextState  = ST_IDLE;
      nextCnt    = '0;
      stb.clrAll = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (opStart) begin
            nextState   = ST_RUN;
            nextKind    = opKind_e'(opKind);
            stb.clrFail = 1'b1;
          end
        end
        ST_RUN: begin
          if (opFail) begin
            nextState   = ST_IDLE;
            stb.setFail = 1'b1;
          end else if (opDone) begin
            nextState = ST_IDLE;
          end else if (suspendReq && welIn && suspendable) begin
            nextState = ST_SUSPENDING;
            nextCnt   = SUSP_LOAD;
          end
        end
        ST_SUSPENDING: begin
          if (cnt == '0) begin
            nextState = ST_SUSPENDED;
            if (kind == KIND_ERASE) stb.setEraseSusp = 1'b1;
            else                    stb.setProgSusp  = 1'b1;
          end else begin
            nextCnt = cnt - 1'b1;
          end
        end
        ST_SUSPENDED: begin
          if (resumeReq && welIn) begin
            nextState = ST_RESUMING;
            nextCnt   = RES_LOAD;
          end
        end
        ST_RESUMING: begin
          if (cnt == '0) begin
            nextState   = ST_RUN;
            stb.clrSusp = 1'b1;
          end else begin
            nextCnt = cnt - 1'b1;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      kind  <= KIND_PROG;
      cnt   <= '0;
    end else begin
      state <= nextState;
      kind  <= nextKind;
      cnt   <= nextCnt;
    end
  end

  assign wip = (state == ST_RUN) || (state == ST_SUSPENDING) || (state == ST_RESUMING);

endmodule

// File: rtl/suspstat_dp.sv
module suspstat_dp
  import suspstat_pkg::*;
#(
  parameter int          OPC_W     = 8,
  parameter logic [7:0]  RD_OPCODE = 8'h09
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     stb,
  input  logic             wip,
  input  logic             welIn,
  input  logic             cmdValid,
  input  logic [OPC_W-1:0] cmdOpcode,
  output logic [STATUS_W-1:0] statusByte,
  output logic             sdo,
  output logic             sdoValid
);

  localparam int BCNT_W = $clog2(STATUS_W + 1);

  logic failBit, progSusp, eraseSusp;
  logic [STATUS_W-1:0] shiftReg;
  logic [BCNT_W-1:0]   bitsLeft;
  logic                readHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failBit   <= 1'b0;
      progSusp  <= 1'b0;
      eraseSusp <= 1'b0;
    end else if (stb.clrAll) begin
      failBit   <= 1'b0;
      progSusp  <= 1'b0;
      eraseSusp <= 1'b0;
    end else begin
      if (stb.setFail)           failBit <= 1'b1;
      else if (stb.clrFail)      failBit <= 1'b0;
      if (stb.setEraseSusp)      eraseSusp <= 1'b1;
      if (stb.setProgSusp)       progSusp  <= 1'b1;
      if (stb.clrSusp) begin
        eraseSusp <= 1'b0;
        progSusp  <= 1'b0;
      end
    end
  end

  // Assemble the byte; unlisted positions stay 0.
  always_comb begin
    statusByte           = '0;
    statusByte[BIT_WIP]  = wip;
    statusByte[BIT_FAIL] = failBit;
    statusByte[BIT_PSUS] = progSusp;
    statusByte[BIT_ESUS] = eraseSusp;
    statusByte[BIT_WEL]  = welIn;
  end

  assign readHit = cmdValid && (cmdOpcode == OPC_W'(RD_OPCODE)) && (bitsLeft == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitsLeft <= '0;
    end else if (readHit) begin
      shiftReg <= statusByte;
      bitsLeft <= BCNT_W'(STATUS_W);
    end else if (bitsLeft != '0) begin
      shiftReg <= {shiftReg[STATUS_W-2:0], 1'b0};
      bitsLeft <= bitsLeft - 1'b1;
    end
  end

  assign sdoValid = (bitsLeft != '0);
  assign sdo      = sdoValid & shiftReg[STATUS_W-1];

endmodule

// File: rtl/suspstat_top.sv
module suspstat_top
  import suspstat_pkg::*;
#(
  parameter int         SUSP_CYCLES = 4,
  parameter int         RES_CYCLES  = 3,
  parameter int         OPC_W       = 8,
  parameter logic [7:0] RD_OPCODE   = 8'h09
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             swReset,
  input  logic             opStart,
  input  logic [1:0]       opKind,
  input  logic             opDone,
  input  logic             opFail,
  input  logic             suspendReq,
  input  logic             resumeReq,
  input  logic             welIn,
  input  logic             cmdValid,
  input  logic [OPC_W-1:0] cmdOpcode,
  output logic             wip,
  output logic [7:0]       suspStatus,
  output logic             sdo,
  output logic             sdoValid
);

  ctrlStrobes_t stb;

  suspstat_ctrl #(
    .SUSP_CYCLES(SUSP_CYCLES),
    .RES_CYCLES (RES_CYCLES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .swReset   (swReset),
    .opStart   (opStart),
    .opKind    (opKind),
    .opDone    (opDone),
    .opFail    (opFail),
    .suspendReq(suspendReq),
    .resumeReq (resumeReq),
    .welIn     (welIn),
    .stb       (stb),
    .wip       (wip)
  );

  suspstat_dp #(
    .OPC_W    (OPC_W),
    .RD_OPCODE(RD_OPCODE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wip       (wip),
    .welIn     (welIn),
    .cmdValid  (cmdValid),
    .cmdOpcode (cmdOpcode),
    .statusByte(suspStatus),
    .sdo       (sdo),
    .sdoValid  (sdoValid)
  );

endmodule

// File: rtl/suspstat_checker.sv
module suspstat_checker #(
  parameter int         OPC_W     = 8,
  parameter logic [7:0] RD_OPCODE = 8'h09
) (
  input logic             clk,
  input logic             rstN,
  input logic             swReset,
  input logic             opStart,
  input logic             welIn,
  input logic             cmdValid,
  input logic [OPC_W-1:0] cmdOpcode,
  input logic             wip,
  input logic [7:0]       suspStatus,
  input logic             sdoValid
);

  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (suspStatus[6] == 1'b0) && (suspStatus[4] == 1'b0) && (suspStatus[0] == 1'b0));

  p_busy_mirror_r10: assert property (@(posedge clk) disable iff (!rstN)
    suspStatus[7] == wip);

  p_one_suspended_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(suspStatus[3] && suspStatus[2]));

  p_erase_susp_from_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(suspStatus[2]) |-> $past(wip));

  p_prog_susp_from_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(suspStatus[3]) |-> $past(wip));

  // R5: leaving the suspended state needs the write-enable latch.
  p_resume_gated_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(wip) && (suspStatus[3] || suspStatus[2])) |-> $past(welIn));

  p_fail_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(suspStatus[5]) && !$past(swReset) && !$past(opStart)) |-> suspStatus[5]);

  p_read_starts_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOpcode == OPC_W'(RD_OPCODE) && !sdoValid) |=> sdoValid);

  p_swreset_clears_r11: assert property (@(posedge clk) disable iff (!rstN)
    swReset |=> (!wip && suspStatus[5:2] == 4'b0000));

endmodule

bind suspstat_top suspstat_checker #(
  .OPC_W    (OPC_W),
  .RD_OPCODE(RD_OPCODE)
) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .swReset   (swReset),
  .opStart   (opStart),
  .welIn     (welIn),
  .cmdValid  (cmdValid),
  .cmdOpcode (cmdOpcode),
  .wip       (wip),
  .suspStatus(suspStatus),
  .sdoValid  (sdoValid)
);

// File: tb/suspstat_top_test.sv
`timescale 1ns/1ps
module suspstat_top_test;

  localparam int SUSP = 4;
  localparam int RES  = 3;
  localparam int NVEC = 18;

  // Event codes: 0 none, 1 start, 2 suspend, 3 resume, 4 done, 5 fail, 6 software reset
  // Vector fields: {event[2:0], kind[1:0], wel, waitClocks[7:0], expected[7:0]}
  localparam logic [21:0] VEC [NVEC] = '{
    {3'd1, 2'd1, 1'b1, 8'd0,  8'h82},  // R10 erase running
    {3'd2, 2'd0, 1'b1, 8'd4,  8'h06},  // R2 erase suspended
    {3'd3, 2'd0, 1'b1, 8'd3,  8'h82},  // R4 erase resumed
    {3'd4, 2'd0, 1'b1, 8'd0,  8'h02},  // R10 done
    {3'd2, 2'd0, 1'b1, 8'd5,  8'h02},  // R6 suspend while idle
    {3'd3, 2'd0, 1'b1, 8'd4,  8'h02},  // R6 resume with nothing suspended
    {3'd1, 2'd0, 1'b1, 8'd0,  8'h82},  // R10 program running
    {3'd2, 2'd0, 1'b0, 8'd5,  8'h80},  // R5 suspend with latch low
    {3'd2, 2'd0, 1'b1, 8'd4,  8'h0A},  // R3 program suspended
    {3'd3, 2'd0, 1'b0, 8'd4,  8'h08},  // R5 resume with latch low
    {3'd3, 2'd0, 1'b1, 8'd3,  8'h82},  // R4 program resumed
    {3'd5, 2'd0, 1'b1, 8'd0,  8'h22},  // R7 fail latched
    {3'd2, 2'd0, 1'b1, 8'd5,  8'h22},  // R7 fail holds while idle
    {3'd1, 2'd1, 1'b1, 8'd0,  8'h82},  // R7 new start clears fail
    {3'd5, 2'd0, 1'b1, 8'd0,  8'h22},  // R7 fail again
    {3'd6, 2'd0, 1'b1, 8'd0,  8'h02},  // R11 software reset clears fail
    {3'd1, 2'd2, 1'b1, 8'd0,  8'h82},  // R6 status write running
    {3'd2, 2'd0, 1'b1, 8'd5,  8'h82}   // R6 status write not suspendable
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       swReset = 1'b0, opStart = 1'b0, opDone = 1'b0, opFail = 1'b0;
  logic       suspendReq = 1'b0, resumeReq = 1'b0, welIn = 1'b0, cmdValid = 1'b0;
  logic [1:0] opKind = 2'd0;
  logic [7:0] cmdOpcode = 8'h00;
  logic       wip, sdo, sdoValid;
  logic [7:0] suspStatus;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  suspstat_top #(.SUSP_CYCLES(SUSP), .RES_CYCLES(RES)) uut (
    .clk(clk), .rstN(rstN), .swReset(swReset), .opStart(opStart), .opKind(opKind),
    .opDone(opDone), .opFail(opFail), .suspendReq(suspendReq), .resumeReq(resumeReq),
    .welIn(welIn), .cmdValid(cmdValid), .cmdOpcode(cmdOpcode), .wip(wip),
    .suspStatus(suspStatus), .sdo(sdo), .sdoValid(sdoValid)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic applyEv(input logic [2:0] ev, input logic [1:0] kind, input logic wel);
    @(negedge clk);
    welIn      = wel;
    opKind     = kind;
    opStart    = (ev == 3'd1);
    suspendReq = (ev == 3'd2);
    resumeReq  = (ev == 3'd3);
    opDone     = (ev == 3'd4);
    opFail     = (ev == 3'd5);
    swReset    = (ev == 3'd6);
    @(negedge clk);
    {opStart, suspendReq, resumeReq, opDone, opFail, swReset} = '0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20ns * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [7:0] got;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 status", suspStatus, 8'h00);
    check("R1 outputs", {5'd0, wip, sdo, sdoValid}, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    welIn = 1'b1;
    @(negedge clk);
    check("R1 latch mirror", suspStatus, 8'h02);

    for (int i = 0; i < NVEC; i++) begin
      applyEv(VEC[i][21:19], VEC[i][18:17], VEC[i][16]);
      repeat (int'(VEC[i][15:8])) @(negedge clk);
      check($sformatf("vector %0d", i), suspStatus, VEC[i][7:0]);
    end
    applyEv(3'd4, 2'd0, 1'b1);

    // R2/R10 transition length: busy one clock before the edge, then suspended
    applyEv(3'd1, 2'd1, 1'b1);
    applyEv(3'd2, 2'd0, 1'b1);
    repeat (SUSP - 1) @(negedge clk);
    check("R10 busy during suspend", suspStatus, 8'h82);
    @(negedge clk);
    check("R2 suspended at edge", suspStatus, 8'h06);

    // R9 serial read of the suspended state
    @(negedge clk);
    cmdValid = 1'b1; cmdOpcode = 8'h09;
    @(negedge clk);
    cmdValid = 1'b0;
    got = 8'h00;
    for (int b = 0; b < 8; b++) begin
      check("R9 valid while shifting", {7'd0, sdoValid}, 8'h01);
      got = {got[6:0], sdo};
      @(negedge clk);
    end
    check("R9 serial byte", got, 8'h06);
    check("R9 valid ends", {7'd0, sdoValid}, 8'h00);

    // R9 other opcode
    cmdValid = 1'b1; cmdOpcode = 8'h05;
    @(negedge clk);
    cmdValid = 1'b0;
    check("R9 other opcode silent", {7'd0, sdoValid}, 8'h00);

    // R4 resume timing: busy at once, suspended bit held until edge
    applyEv(3'd3, 2'd0, 1'b1);
    repeat (RES - 1) @(negedge clk);
    check("R4 resume in progress", suspStatus, 8'h86);
    @(negedge clk);
    check("R4 resumed", suspStatus, 8'h82);

    // R11 software reset from suspended
    applyEv(3'd2, 2'd0, 1'b1);
    repeat (SUSP) @(negedge clk);
    applyEv(3'd6, 2'd0, 1'b1);
    check("R11 reset from suspended", suspStatus, 8'h02);
    applyEv(3'd3, 2'd0, 1'b1);
    repeat (RES + 1) @(negedge clk);
    check("R11 no resume after reset", suspStatus, 8'h02);

    finishRun();
  end

endmodule